// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one prefixed instruction into a series of per-element issue requests. The front end offers a decoded instruction carrying three base register numbers, a vector length and a mode bit. The sequencer then emits one request per element. Each request carries the element index and the three register numbers, each shifted by that index. The register fields are wider than the 5-bit suffix fields, so they can address an extended register file.

The mode bit selects one of two iteration orders. In horizontal-first mode (`in_vf` = 0), every element of an instruction is issued, starting from element 0, before the next instruction is accepted. In vertical-first mode (`in_vf` = 1), exactly one element is issued per instruction. Its index is a persistent offset that stays the same from one instruction to the next. Only a separate step command moves that offset forward, and it wraps to zero when it passes the end of the vector.

The front end sees a stall through `in_ready` and a completion pulse on `done`. The issue side uses a valid/ready handshake.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `iss_valid`, `done` and `loop_end` are 0, and `vf_offset` is 0.
- R2: A horizontal-first instruction with length N issues exactly N requests with `iss_elem` = 0, 1, …, N-1 in order, starting from 0 for every instruction, whatever the vertical-first offset is.
- R3: Each issued register number equals its base plus the element index, modulo 2^7 (7-bit register fields).
- R4: `in_ready` is 0 while requests of an accepted instruction remain to be issued, and it is never 1 while `iss_valid` is 1.
- R5: `done` is high for exactly one cycle, in the cycle after the handshake of the final request of an instruction.
- R6: While `iss_valid` is 1 and `iss_ready` is 0, the request stays valid and its element index and register numbers do not change.
- R7: A vertical-first instruction issues exactly one request, with `iss_elem` equal to `vf_offset`. A following vertical-first instruction reuses the same offset.
- R8: `vf_offset` changes only in the cycle after `step_cmd` is 1. A step raises it by one unless R9 applies.
- R9: A step for which offset+1 is greater than or equal to the held length sets `vf_offset` to 0 and raises `loop_end` for one cycle. The held length is the length of the most recently accepted instruction, and it is 0 after reset.
- R10: An instruction with length 0, or a vertical-first instruction whose offset is not below its length, issues no request and raises `done` in the cycle after acceptance.
- R11: When a step and the acceptance of an instruction fall in the same cycle, the instruction uses the offset from before the step, and the step compares against the held length from before that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Front end offers an instruction |
| in_ready | output | 1 | Sequencer can accept an instruction (low = stall) |
| in_vf | input | 1 | 1 = vertical-first, 0 = horizontal-first |
| in_vl | input | 7 | Vector length |
| in_rt | input | 7 | Base register number, operand 0 |
| in_ra | input | 7 | Base register number, operand 1 |
| in_rb | input | 7 | Base register number, operand 2 |
| step_cmd | input | 1 | Advance the vertical-first offset |
| iss_valid | output | 1 | Element request valid |
| iss_ready | input | 1 | Downstream accepts the request |
| iss_elem | output | 7 | Element index of the request |
| iss_rt | output | 7 | Offset register number, operand 0 |
| iss_ra | output | 7 | Offset register number, operand 1 |
| iss_rb | output | 7 | Offset register number, operand 2 |
| done | output | 1 | One-cycle completion pulse |
| loop_end | output | 1 | One-cycle pulse when a step wraps the offset |
| vf_offset | output | 7 | Current vertical-first offset |

## Verification
Two functions can meet in one cycle: a step command can arrive in the same cycle that a vertical-first instruction is accepted, so the offset update and the capture of the element index coincide. The bench first steps the offset to a value just below the held length, then drives `step_cmd` and `in_valid` together. It expects the issued element to be the pre-step offset, and it expects the wrap and `loop_end` to be decided by the old held length rather than the new one. Backpressure during an issue sequence is also mixed with the `done` timing to show that the completion pulse follows the last handshake and not the last valid cycle.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int VSEQ_REG_W = 7;
  localparam int VSEQ_VL_W  = 7;
  localparam int VSEQ_NOPS  = 3;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } seq_st_e;
endpackage

// File: rtl/vseq_rstsync.sv
module vseq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/vseq_vfoff.sv
module vseq_vfoff #(
  parameter int VL_W = vseq_pkg::VSEQ_VL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            acc,
  input  logic [VL_W-1:0] acc_vl,
  output logic [VL_W-1:0] offset,
  output logic            wrap
);
  logic [VL_W-1:0] off_q, off_d, hvl_q;
  logic [VL_W:0]   nxt;
  logic            wrap_q, wrap_d;

  always_comb begin
    nxt    = {1'b0, off_q} + {{VL_W{1'b0}}, 1'b1};
    wrap_d = step && (nxt >= {1'b0, hvl_q});
    off_d  = wrap_d ? '0 : nxt[VL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      hvl_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_d;
      if (step) off_q <= off_d;
      if (acc)  hvl_q <= acc_vl;
    end
  end

  assign offset = off_q;
  assign wrap   = wrap_q;
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int VL_W = VSEQ_VL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_vf,
  input  logic [VL_W-1:0] in_vl,
  input  logic [VL_W-1:0] vf_off,
  input  logic            iss_ready,
  output logic            in_ready,
  output logic            acc,
  output logic            iss_valid,
  output logic [VL_W-1:0] elem,
  output logic            done
);
  seq_st_e         st_q, st_d;
  logic            vf_q;
  logic [VL_W-1:0] vl_q, elem_q, elem_d;
  logic            elem_en, done_d, done_q, last_elem;

  assign in_ready  = (st_q == ST_IDLE);
  assign acc       = in_valid && in_ready;
  assign iss_valid = (st_q == ST_ISSUE);
  assign last_elem = vf_q || (elem_q == vl_q - {{(VL_W-1){1'b0}}, 1'b1});

  always_comb begin
    st_d    = st_q;
    elem_d  = elem_q;
    elem_en = 1'b0;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (acc) begin
          if (in_vf) begin
            if (vf_off < in_vl) begin
              st_d    = ST_ISSUE;
              elem_d  = vf_off;
              elem_en = 1'b1;
            end else begin
              done_d = 1'b1;
            end
          end else if (in_vl != '0) begin
            st_d    = ST_ISSUE;
            elem_d  = '0;
            elem_en = 1'b1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (iss_ready) begin
          if (last_elem) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            elem_d  = elem_q + {{(VL_W-1){1'b0}}, 1'b1};
            elem_en = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      vf_q   <= 1'b0;
      vl_q   <= '0;
      elem_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (acc) begin
        vf_q <= in_vf;
        vl_q <= in_vl;
      end
      if (elem_en) elem_q <= elem_d;
    end
  end

  assign elem = elem_q;
  assign done = done_q;
endmodule

// File: rtl/vseq_regoff.sv
module vseq_regoff #(
  parameter int REG_W = vseq_pkg::VSEQ_REG_W,
  parameter int VL_W  = vseq_pkg::VSEQ_VL_W,
  parameter int NOPS  = vseq_pkg::VSEQ_NOPS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NOPS-1:0][REG_W-1:0] base_in,
  input  logic [VL_W-1:0]            elem,
  output logic [NOPS-1:0][REG_W-1:0] reg_out
);
  logic [NOPS-1:0][REG_W-1:0] base_q;
  logic [REG_W-1:0]           step_ext;

  generate
    if (VL_W >= REG_W) begin : g_trunc
      assign step_ext = elem[REG_W-1:0];
    end else begin : g_zext
      assign step_ext = {{(REG_W-VL_W){1'b0}}, elem};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_in;
  end

  generate
    for (genvar i = 0; i < NOPS; i++) begin : g_op
      assign reg_out[i] = base_q[i] + step_ext;
    end
  endgenerate
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int REG_W = vseq_pkg::VSEQ_REG_W,
  parameter int VL_W  = vseq_pkg::VSEQ_VL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_vf,
  input  logic [VL_W-1:0]  in_vl,
  input  logic [REG_W-1:0] in_rt,
  input  logic [REG_W-1:0] in_ra,
  input  logic [REG_W-1:0] in_rb,
  input  logic             step_cmd,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [VL_W-1:0]  iss_elem,
  output logic [REG_W-1:0] iss_rt,
  output logic [REG_W-1:0] iss_ra,
  output logic [REG_W-1:0] iss_rb,
  output logic             done,
  output logic             loop_end,
  output logic [VL_W-1:0]  vf_offset
);
  localparam int NOPS = vseq_pkg::VSEQ_NOPS;

  logic                       srst_n, acc;
  logic [VL_W-1:0]            off;
  logic [NOPS-1:0][REG_W-1:0] base_vec, reg_vec;

  assign base_vec = {in_rb, in_ra, in_rt};

  vseq_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  vseq_vfoff #(.VL_W(VL_W)) u_off (
    .clk    (clk),
    .rst_n  (srst_n),
    .step   (step_cmd),
    .acc    (acc),
    .acc_vl (in_vl),
    .offset (off),
    .wrap   (loop_end)
  );

  vseq_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_valid  (in_valid),
    .in_vf     (in_vf),
    .in_vl     (in_vl),
    .vf_off    (off),
    .iss_ready (iss_ready),
    .in_ready  (in_ready),
    .acc       (acc),
    .iss_valid (iss_valid),
    .elem      (iss_elem),
    .done      (done)
  );

  vseq_regoff #(.REG_W(REG_W), .VL_W(VL_W), .NOPS(NOPS)) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (acc),
    .base_in (base_vec),
    .elem    (iss_elem),
    .reg_out (reg_vec)
  );

  assign iss_rt    = reg_vec[0];
  assign iss_ra    = reg_vec[1];
  assign iss_rb    = reg_vec[2];
  assign vf_offset = off;
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int REG_W = vseq_pkg::VSEQ_REG_W,
  parameter int VL_W  = vseq_pkg::VSEQ_VL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             step_cmd,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [VL_W-1:0]  iss_elem,
  input logic [REG_W-1:0] iss_rt,
  input logic [REG_W-1:0] iss_ra,
  input logic [REG_W-1:0] iss_rb,
  input logic             done,
  input logic             loop_end,
  input logic [VL_W-1:0]  vf_offset
);
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_elem) && $stable(iss_rt)
                                   && $stable(iss_ra) && $stable(iss_rb)));

  assert_no_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !in_ready);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !iss_valid);

  assert_offset_only_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_cmd |=> $stable(vf_offset));

  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end |-> (vf_offset == '0));

  assert_wrap_after_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end |-> $past(step_cmd));
endmodule

bind vec_elem_seq vseq_chk #(.REG_W(REG_W), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .step_cmd  (step_cmd),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_elem  (iss_elem),
  .iss_rt    (iss_rt),
  .iss_ra    (iss_ra),
  .iss_rb    (iss_rb),
  .done      (done),
  .loop_end  (loop_end),
  .vf_offset (vf_offset)
);

// File: tb/test_vec_elem_seq.sv
`timescale 1ns/1ps
module test_vec_elem_seq;
  typedef struct packed {
    logic [6:0] e;
    logic [6:0] rt;
    logic [6:0] ra;
    logic [6:0] rb;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n, in_valid, in_vf, step_cmd, iss_ready;
  logic [6:0] in_vl, in_rt, in_ra, in_rb;
  logic       in_ready, iss_valid, done, loop_end;
  logic [6:0] iss_elem, iss_rt, iss_ra, iss_rb, vf_offset;

  item_t expq[$];
  int    nchk = 0, nfail = 0;
  int    cyc = 0, last_hs = -10, acc_cyc = 0;
  int    m_off = 0, m_vl = 0;
  int    rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  vec_elem_seq i_vec_elem_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vf(in_vf), .in_vl(in_vl), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
    .step_cmd(step_cmd), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_elem(iss_elem), .iss_rt(iss_rt), .iss_ra(iss_ra), .iss_rb(iss_rb),
    .done(done), .loop_end(loop_end), .vf_offset(vf_offset)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic item_t mk(int e, int rt, int ra, int rb);
    return item_t'{7'(e), 7'((rt + e) % 128), 7'((ra + e) % 128), 7'((rb + e) % 128)};
  endfunction

  // downstream ready pattern: 0 = always ready, 1 = pseudo-random, 2 = stalled
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    iss_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  // monitor: pops the scoreboard on every issue handshake
  always @(negedge clk) begin
    item_t x;
    #1;
    if (rst_n && iss_valid && iss_ready) begin
      if (expq.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R2 unexpected issue actual elem=%0d expected=none", iss_elem);
      end else begin
        x = expq.pop_front();
        chk("R2/R7 elem", iss_elem, x.e);
        chk("R3 rt", iss_rt, x.rt);
        chk("R3 ra", iss_ra, x.ra);
        chk("R3 rb", iss_rb, x.rb);
      end
      last_hs = cyc;
    end
  end

  task automatic push_exp(bit vf, int vl, int rt, int ra, int rb);
    if (vf) begin
      if (m_off < vl) expq.push_back(mk(m_off, rt, ra, rb));
    end else begin
      for (int e = 0; e < vl; e++) expq.push_back(mk(e, rt, ra, rb));
    end
  endtask

  task automatic send(bit vf, int vl, int rt, int ra, int rb, bit with_step);
    @(negedge clk);
    in_valid = 1'b1; in_vf = vf; in_vl = 7'(vl);
    in_rt = 7'(rt); in_ra = 7'(ra); in_rb = 7'(rb);
    step_cmd = with_step;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    @(negedge clk);
    in_valid = 1'b0; step_cmd = 1'b0;
  endtask

  task automatic finish_instr(bit issued);
    int t = 0;
    #1;
    while (!done && t < 2000) begin @(negedge clk); #1; t++; end
    chk("R5 done seen", done, 1);
    if (issued) chk("R5 done after last handshake", cyc, last_hs + 1);
    else        chk("R10 done after accept", cyc, acc_cyc + 1);
    chk("R2 all requests issued", expq.size(), 0);
    @(negedge clk); #1;
    chk("R5 done single cycle", done, 0);
    @(negedge clk);
  endtask

  task automatic run(bit vf, int vl, int rt, int ra, int rb);
    bit issued;
    issued = vf ? (m_off < vl) : (vl > 0);
    push_exp(vf, vl, rt, ra, rb);
    send(vf, vl, rt, ra, rb, 1'b0);
    m_vl = vl;
    finish_instr(issued);
  endtask

  task automatic do_step();
    bit w;
    w = (m_off + 1 >= m_vl);
    m_off = w ? 0 : m_off + 1;
    @(negedge clk); step_cmd = 1'b1;
    @(negedge clk); step_cmd = 1'b0;
    #1;
    chk("R8 offset after step", vf_offset, m_off);
    chk("R9 loop_end on step", loop_end, w);
    @(negedge clk); #1;
    chk("R9 loop_end one cycle", loop_end, 0);
    chk("R8 offset held", vf_offset, m_off);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_vf = 1'b0; step_cmd = 1'b0;
    in_vl = '0; in_rt = '0; in_ra = '0; in_rb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 loop_end", loop_end, 0);
    chk("R1 vf_offset", vf_offset, 0);
    @(negedge clk);

    // R2 horizontal-first, no backpressure
    run(0, 4, 3, 10, 20);
    // R2/R5 horizontal-first with random backpressure
    rdy_mode = 1;
    run(0, 5, 40, 50, 60);
    rdy_mode = 0;

    // R6 / R4: stalled downstream holds the first request
    push_exp(0, 3, 1, 2, 3);
    rdy_mode = 2;
    send(0, 3, 1, 2, 3, 1'b0);
    m_vl = 3;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R6 valid held", iss_valid, 1);
      chk("R6 elem held", iss_elem, 0);
      chk("R6 rt held", iss_rt, 1);
      chk("R4 stalled front end", in_ready, 0);
      if (i == 2) rdy_mode = 0;
      @(negedge clk);
    end
    finish_instr(1'b1);

    // R3 register wrap modulo 128
    run(0, 6, 125, 127, 0);
    // R10 zero length
    run(0, 0, 9, 9, 9);

    // R7 vertical-first reuses the offset
    run(1, 8, 10, 20, 30);
    run(1, 8, 70, 80, 90);
    do_step();
    run(1, 8, 5, 6, 7);
    chk("R8 offset unchanged by instruction", vf_offset, m_off);

    // R9 wrap at held length 8
    for (int i = 0; i < 7; i++) do_step();

    // R10 vertical-first with offset not below length
    for (int i = 0; i < 5; i++) do_step();
    run(1, 3, 11, 12, 13);

    // R11 step and accept in the same cycle
    do_step();
    do_step();
    do_step();
    push_exp(1, 8, 100, 101, 102);
    begin
      bit w;
      w = (m_off + 1 >= m_vl);
      m_off = w ? 0 : m_off + 1;
      send(1, 8, 100, 101, 102, 1'b1);
      m_vl = 8;
      #1;
      chk("R11 loop_end uses old length", loop_end, w);
      chk("R11 offset after joint step", vf_offset, m_off);
      @(negedge clk);
      finish_instr(1'b1);
    end

    // R2 horizontal-first restarts at zero with nonzero offset
    do_step();
    run(0, 3, 15, 16, 17);
    #1;
    chk("R8 offset untouched by horizontal-first", vf_offset, m_off);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule